// File: doc/BRIEF.md
# Two-Operand NaN Propagation Selector

This block settles which input NaN a two-operand floating-point operation passes on to its result. Each operand arrives with a class code. A single-bit hint tells the block whether operand A has the larger significand. The block returns a registered verdict that says which operand to forward, whether that operand has to be turned into a quiet NaN first, whether the invalid-operation flag must be raised, and whether the datapath should emit the default NaN instead of either operand.

The upstream datapath computes the significand comparison and passes it in. The downstream result-forming logic builds the final NaN value from the verdict. A two-bit rule select picks one of four priority schemes at run time. The first scheme prefers signaling over quiet NaNs and A over B. The second always prefers the first NaN. The third follows a run-time first/last preference bit. The fourth decides by signaling/quiet kind and by significand magnitude.

A default-NaN mode input overrides the choice of operand but keeps the invalid flag. Inputs are taken when `in_valid` is high, and the verdict appears one clock later with `out_valid`.

Top module: `nan_pick_unit`

## Requirements
- R1: The verdict registers load only in a cycle where `in_valid` is high, and `out_valid` is high exactly in the cycle after such a cycle. While `in_valid` is low, `out_valid` falls, and `sel_b`, `quieten`, `invalid`, `no_nan` and `use_default` keep their values.
- R2: Class codes are 2'b00 for a number, 2'b01 for a quiet NaN and 2'b10 for a signaling NaN. Code 2'b11 is treated as a number. When neither operand is a NaN, `no_nan`=1 and `sel_b`, `quieten`, `invalid` and `use_default` are all 0.
- R3: With `rule_sel`=0 the selected operand is the first match in this order: A if signaling, B if signaling, A if quiet, otherwise B.
- R4: With `rule_sel`=1, A is selected whenever A is any NaN; otherwise B is selected.
- R5: With `rule_sel`=2 and `pick_first`=1, A is selected when A is any NaN, otherwise B. With `pick_first`=0, B is selected when B is any NaN, otherwise A.
- R6: With `rule_sel`=3, when one operand is signaling and the other is quiet, the quiet one is selected.
- R7: With `rule_sel`=3, when both operands are NaNs of the same kind, A is selected if `a_larger`=1 and B otherwise. `a_larger` is defined as A having the larger significand, or equal significands with A positive and B negative.
- R8: With `rule_sel`=3, when exactly one operand is a NaN, that operand is selected.
- R9: `quieten`=1 exactly when an operand is forwarded (default mode off) and the forwarded operand is signaling.
- R10: `invalid`=1 exactly when either operand is signaling, with or without default mode.
- R11: With `dflt_mode`=1 and at least one NaN input, `use_default`=1, `sel_b`=0 and `quieten`=0.
- R12: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Inputs are valid this cycle |
| cls_a | input | 2 | Class code of operand A |
| cls_b | input | 2 | Class code of operand B |
| a_larger | input | 1 | A's significand wins the magnitude tie-break |
| rule_sel | input | 2 | Priority scheme 0..3 |
| pick_first | input | 1 | Scheme 2: 1 prefers A, 0 prefers B |
| dflt_mode | input | 1 | Request default NaN instead of an operand |
| out_valid | output | 1 | Verdict valid |
| sel_b | output | 1 | 0 forwards A, 1 forwards B |
| quieten | output | 1 | Forwarded operand must be made quiet |
| invalid | output | 1 | Invalid-operation flag |
| no_nan | output | 1 | Neither operand is a NaN |
| use_default | output | 1 | Emit the default NaN |

## Verification
The bench goes after the mixed signaling/quiet pairs under scheme 3. A design that ranks the signaling NaN first, as scheme 0 does, would forward the wrong operand there. It sweeps `a_larger` on same-kind pairs, where ignoring the hint would always forward A. It flips `pick_first` under scheme 2, where a design that drops the bit behaves like scheme 1. It also targets code 2'b11 and default mode with signaling inputs. Getting those wrong would report a phantom NaN, lose the invalid flag, or request quietening of an operand that is never forwarded. Holding `in_valid` low while inputs change exposes a verdict register that loads every cycle.

// File: rtl/nanpick_pkg.sv
package nanpick_pkg;
   localparam int unsigned CLASS_W = 2;
   localparam logic [CLASS_W-1:0] CLS_NUM  = 2'b00;
   localparam logic [CLASS_W-1:0] CLS_QNAN = 2'b01;
   localparam logic [CLASS_W-1:0] CLS_SNAN = 2'b10;

   typedef enum logic [1:0] {
      RULE_SIG_FIRST = 2'd0,
      RULE_FIRST_NAN = 2'd1,
      RULE_PREF      = 2'd2,
      RULE_MAGNITUDE = 2'd3
   } rule_t;
endpackage

// File: rtl/nanpick_decode.sv
module nanpick_decode #(
   parameter int unsigned N_OPS = 2,
   parameter int unsigned CLS_W = nanpick_pkg::CLASS_W
) (
   input  logic [N_OPS*CLS_W-1:0] cls_vec,
   output logic [N_OPS-1:0]       is_q,
   output logic [N_OPS-1:0]       is_s
);
   generate
      if (CLS_W != 2) begin : g_bad_width
         $error("nanpick_decode: CLS_W must be 2");
      end
      for (genvar i = 0; i < N_OPS; i++) begin : g_op
         logic [CLS_W-1:0] code;
         assign code    = cls_vec[i*CLS_W +: CLS_W];
         assign is_q[i] = (code == nanpick_pkg::CLS_QNAN);
         assign is_s[i] = (code == nanpick_pkg::CLS_SNAN);
      end
   endgenerate
endmodule

// File: rtl/nanpick_rules.sv
module nanpick_rules #(
   parameter int unsigned NUM_RULES = 4,
   localparam int unsigned RULE_W  = $clog2(NUM_RULES)
) (
   input  logic [1:0]        is_q,
   input  logic [1:0]        is_s,
   input  logic              a_larger,
   input  logic              pick_first,
   input  logic [RULE_W-1:0] rule_sel,
   output logic              pick_b
);
   logic [NUM_RULES-1:0] cand;
   logic                 na_a, na_b;

   assign na_a = is_q[0] | is_s[0];
   assign na_b = is_q[1] | is_s[1];

   generate
      if (NUM_RULES != 4) begin : g_bad_rules
         $error("nanpick_rules: exactly four schemes are defined");
      end
      for (genvar r = 0; r < NUM_RULES; r++) begin : g_rule
         if (r == 0) begin : g_sig_first
            assign cand[r] = ~is_s[0] & (is_s[1] | ~is_q[0]);
         end else if (r == 1) begin : g_first_nan
            assign cand[r] = ~na_a;
         end else if (r == 2) begin : g_pref
            assign cand[r] = pick_first ? ~na_a : na_b;
         end else begin : g_magnitude
            always_comb begin
               if (is_s[0])
                  cand[r] = is_s[1] ? ~a_larger : is_q[1];
               else if (is_q[0])
                  cand[r] = is_q[1] & ~a_larger;
               else
                  cand[r] = 1'b1;
            end
         end
      end
   endgenerate

   assign pick_b = cand[rule_sel];
endmodule

// File: rtl/nan_pick_unit.sv
module nan_pick_unit #(
   parameter int unsigned CLS_W     = nanpick_pkg::CLASS_W,
   parameter int unsigned NUM_RULES = 4,
   parameter bit          DFLT_EN   = 1'b1,
   localparam int unsigned RULE_W   = $clog2(NUM_RULES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [CLS_W-1:0]  cls_a,
   input  logic [CLS_W-1:0]  cls_b,
   input  logic              a_larger,
   input  logic [RULE_W-1:0] rule_sel,
   input  logic              pick_first,
   input  logic              dflt_mode,
   output logic              out_valid,
   output logic              sel_b,
   output logic              quieten,
   output logic              invalid,
   output logic              no_nan,
   output logic              use_default
);
   logic [1:0] is_q, is_s;
   logic       pick_b, any_nan, dflt_hit, sel_n, quiet_n, dflt_allowed;

   nanpick_decode #(.N_OPS(2), .CLS_W(CLS_W)) u_dec (
      .cls_vec ({cls_b, cls_a}),
      .is_q    (is_q),
      .is_s    (is_s)
   );

   nanpick_rules #(.NUM_RULES(NUM_RULES)) u_rules (
      .is_q       (is_q),
      .is_s       (is_s),
      .a_larger   (a_larger),
      .pick_first (pick_first),
      .rule_sel   (rule_sel),
      .pick_b     (pick_b)
   );

   generate
      if (DFLT_EN) begin : g_dflt
         assign dflt_allowed = dflt_mode;
      end else begin : g_no_dflt
         assign dflt_allowed = 1'b0;
      end
   endgenerate

   assign any_nan  = |(is_q | is_s);
   assign dflt_hit = dflt_allowed & any_nan;
   assign sel_n    = any_nan & ~dflt_hit & pick_b;
   assign quiet_n  = any_nan & ~dflt_hit & (sel_n ? is_s[1] : is_s[0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         sel_b       <= 1'b0;
         quieten     <= 1'b0;
         invalid     <= 1'b0;
         no_nan      <= 1'b0;
         use_default <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            sel_b       <= sel_n;
            quieten     <= quiet_n;
            invalid     <= |is_s;
            no_nan      <= ~any_nan;
            use_default <= dflt_hit;
         end
      end
   end

   // R1: verdict appears one cycle after acceptance, holds otherwise
   p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(sel_b) && $stable(invalid)));
   // R10: invalid tracks signaling inputs at the ports
   p_invalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (invalid == ($past(cls_a) == nanpick_pkg::CLS_SNAN ||
                                 $past(cls_b) == nanpick_pkg::CLS_SNAN)));
   // R9: only a forwarded signaling operand is quietened
   p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && quieten) |-> (!use_default &&
         ((sel_b ? $past(cls_b) : $past(cls_a)) == nanpick_pkg::CLS_SNAN)));
   // R2: no NaN means a clean verdict
   p_nonan_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && no_nan) |-> (!sel_b && !invalid && !quieten && !use_default));
   // R11: default NaN suppresses operand forwarding
   p_dflt_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && use_default) |-> (!sel_b && !quieten && !no_nan));
   // R4: first-NaN scheme never skips a NaN in A
   p_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && rule_sel == 1 && !dflt_mode &&
       (cls_a == nanpick_pkg::CLS_QNAN || cls_a == nanpick_pkg::CLS_SNAN)) |=> !sel_b);
endmodule

// File: tb/sim_nan_pick_unit.sv
`timescale 1ns/1ps
module sim_nan_pick_unit;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [1:0] cls_a = 2'b00, cls_b = 2'b00, rule_sel = 2'd0;
   logic a_larger = 1'b0, pick_first = 1'b0, dflt_mode = 1'b0;
   logic out_valid, sel_b, quieten, invalid, no_nan, use_default;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   nan_pick_unit u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .cls_a(cls_a), .cls_b(cls_b), .a_larger(a_larger),
      .rule_sel(rule_sel), .pick_first(pick_first), .dflt_mode(dflt_mode),
      .out_valid(out_valid), .sel_b(sel_b), .quieten(quieten),
      .invalid(invalid), .no_nan(no_nan), .use_default(use_default)
   );

   function automatic bit is_nan(input logic [1:0] c);
      return (c == 2'b01) || (c == 2'b10);
   endfunction

   // Scheme choice written from the requirement text
   function automatic bit model_pick(input logic [1:0] ca, input logic [1:0] cb,
                                     input bit al, input logic [1:0] rs, input bit pf);
      case (rs)
         2'd0: begin
            if (ca == 2'b10) return 1'b0;
            if (cb == 2'b10) return 1'b1;
            if (ca == 2'b01) return 1'b0;
            return 1'b1;
         end
         2'd1: return is_nan(ca) ? 1'b0 : 1'b1;
         2'd2: begin
            if (pf) return is_nan(ca) ? 1'b0 : 1'b1;
            return is_nan(cb) ? 1'b1 : 1'b0;
         end
         default: begin
            if (is_nan(ca) && !is_nan(cb)) return 1'b0;
            if (!is_nan(ca)) return 1'b1;
            if (ca != cb) return (ca == 2'b01) ? 1'b0 : 1'b1;
            return al ? 1'b0 : 1'b1;
         end
      endcase
   endfunction

   task automatic check(input string tag, input logic [5:0] got, input logic [5:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: {vld,sel,q,inv,nonan,dflt} got %b expected %b", tag, got, exp);
      end
   endtask

   task automatic apply(input logic [1:0] ca, input logic [1:0] cb, input bit al,
                        input logic [1:0] rs, input bit pf, input bit dm, input string tag);
      bit nn, inv, ud, sel, q;
      @(negedge clk);
      cls_a = ca; cls_b = cb; a_larger = al; rule_sel = rs;
      pick_first = pf; dflt_mode = dm; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      nn  = !(is_nan(ca) || is_nan(cb));
      inv = (ca == 2'b10) || (cb == 2'b10);
      ud  = dm && !nn;
      sel = (nn || ud) ? 1'b0 : model_pick(ca, cb, al, rs, pf);
      q   = !nn && !ud && (((sel ? cb : ca)) == 2'b10);
      check(tag, {out_valid, sel_b, quieten, invalid, no_nan, use_default},
            {1'b1, sel, q, inv, nn, ud});
   endtask

   task automatic t_reset;
      check("R12 reset", {out_valid, sel_b, quieten, invalid, no_nan, use_default}, 6'b0);
   endtask

   task automatic t_rule0;
      for (int a = 0; a < 3; a++)
         for (int b = 0; b < 3; b++)
            if (a != 0 || b != 0) apply(a[1:0], b[1:0], 1'b0, 2'd0, 1'b0, 1'b0, "R3 rule0 / R9 / R10");
   endtask

   task automatic t_rule1;
      for (int a = 0; a < 3; a++)
         for (int b = 0; b < 3; b++)
            if (a != 0 || b != 0) apply(a[1:0], b[1:0], 1'b1, 2'd1, 1'b0, 1'b0, "R4 rule1");
   endtask

   task automatic t_rule2;
      for (int p = 0; p < 2; p++)
         for (int a = 0; a < 3; a++)
            for (int b = 0; b < 3; b++)
               if (a != 0 || b != 0) apply(a[1:0], b[1:0], 1'b0, 2'd2, p[0], 1'b0, "R5 rule2");
   endtask

   task automatic t_rule3;
      for (int l = 0; l < 2; l++)
         for (int a = 0; a < 3; a++)
            for (int b = 0; b < 3; b++) begin
               if (a == 0 && b == 0) continue;
               if (a == 0 || b == 0) apply(a[1:0], b[1:0], l[0], 2'd3, 1'b0, 1'b0, "R8 rule3 single NaN");
               else if (a != b)      apply(a[1:0], b[1:0], l[0], 2'd3, 1'b0, 1'b0, "R6 rule3 mixed kinds");
               else                  apply(a[1:0], b[1:0], l[0], 2'd3, 1'b0, 1'b0, "R7 rule3 tie-break");
            end
   endtask

   task automatic t_no_nan;
      apply(2'b00, 2'b00, 1'b1, 2'd0, 1'b0, 1'b0, "R2 numbers");
      apply(2'b11, 2'b00, 1'b0, 2'd3, 1'b1, 1'b0, "R2 code 11 is a number");
      apply(2'b11, 2'b11, 1'b1, 2'd1, 1'b0, 1'b1, "R2 code 11 with default mode");
      apply(2'b11, 2'b01, 1'b0, 2'd1, 1'b0, 1'b0, "R2 code 11 versus quiet");
   endtask

   task automatic t_default;
      apply(2'b10, 2'b00, 1'b0, 2'd0, 1'b0, 1'b1, "R11 default with signaling A / R10");
      apply(2'b01, 2'b10, 1'b1, 2'd3, 1'b0, 1'b1, "R11 default mixed / R10");
      apply(2'b00, 2'b01, 1'b0, 2'd2, 1'b0, 1'b1, "R11 default quiet B");
   endtask

   task automatic t_hold;
      apply(2'b00, 2'b10, 1'b0, 2'd0, 1'b0, 1'b0, "R1 load");
      @(negedge clk);
      cls_a = 2'b00; cls_b = 2'b00; dflt_mode = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check("R1 hold while idle", {out_valid, sel_b, quieten, invalid, no_nan, use_default},
            6'b011100);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      check("R12 after release", {out_valid, sel_b, quieten, invalid, no_nan, use_default}, 6'b0);
      t_rule0();
      t_rule1();
      t_rule2();
      t_rule3();
      t_no_nan();
      t_default();
      t_hold();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run hung, got timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule